// File: doc/BRIEF.md
# Link Clock-Recovery Training Controller

This block runs the clock-recovery phase of DisplayPort link training on the transmit side. It reaches the sink's configuration registers through an abstract request/response port. On that port it places an address, a write flag and a write byte, then holds `bus_valid` until `bus_ready` accepts the request. It then waits for `bus_done`, which also returns the read byte. After a start pulse it programs the link rate, the lane count and training pattern 1. It then loops: it writes one drive byte per active lane, waits a settle time, and reads back lane status and the sink's adjust requests.

The settle time is counted in microsecond ticks. It is taken from `settle_us` at start. A zero selects a default of 200, and anything below 100 is raised to 100. A total-attempt counter and an identical-request counter end the work at one rate. No other timeout exists. When a rate fails, the controller drops from 5.4 to 2.7 to 1.62 Gbit/s. After the lowest rate fails it reports failure. Both success and final failure turn the training pattern off and produce a one-cycle done pulse with a pass flag.

Top module: `dp_cr_trainer`

## Requirements
- R1: After reset `busy`, `bus_valid` and `train_done` are low, `drive_set` is zero and `rate_code` is 0x14.
- R2: A start pulse issues writes in this order: the rate code to 0x100, `lane_count` to 0x101, 0x01 to 0x102. The rate code is 0x14, 0x0A or 0x06 for 5.4, 2.7 or 1.62 Gbit/s. Next come one drive byte per active lane, to 0x103 plus the lane number, lanes in ascending order.
- R3: A drive byte holds the swing level in bits 1:0 and pre-emphasis in bits 4:3. Bit 2 is set exactly when swing is 2, bit 5 is set exactly when pre-emphasis is 2, and bits 7:6 are zero.
- R4: Between completion of the last drive-byte write and the first status read, exactly N microsecond ticks are counted. N is `settle_us`, except that 0 selects 200 and values from 1 to 99 become 100.
- R5: After the settle time the controller reads 0x202, 0x203, 0x206 and 0x207, in that order. Clock recovery succeeds when bit 0 of every active lane's status nibble is set. Lanes 0 and 1 use bits 0 and 4 of 0x202, and lanes 2 and 3 use bits 0 and 4 of 0x203.
- R6: In 0x206 (lanes 0 and 1) and 0x207 (lanes 2 and 3), each lane's nibble holds the requested swing in its low two bits and pre-emphasis in its high two bits. Lane 0 and lane 2 use bits 3:0, lane 1 and lane 3 use bits 7:4. A request of 3 is clamped to 2. After a failed attempt the clamped request is written as the next drive bytes, so swing can reach level 2. Inactive lanes carry zero.
- R7: A failed attempt whose clamped request equals the currently applied settings on all active lanes is an identical request. Five consecutive identical requests are tolerated, and the sixth ends the current rate.
- R8: The tenth failed attempt at one rate ends that rate. No other time limit ends training.
- R9: When a rate ends without success, training restarts at the next lower rate with settings and both counters cleared. The rate order is 0x14, then 0x0A, then 0x06.
- R10: On success, or when the 0x06 rate fails, the controller writes 0x00 to 0x102. It then raises `train_done` for exactly one cycle, with `train_pass` showing the outcome. `rate_code` and `drive_set` hold the last rate and the last applied settings.
- R11: `bus_valid` with address and data stays stable until `bus_ready`. After acceptance no new request is raised until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins training when idle |
| lane_count | input | 3 | Active lanes: 1, 2 or 4 |
| settle_us | input | 16 | Settle time in microseconds (0 = default) |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_valid | output | 1 | Register request pending |
| bus_ready | input | 1 | Request accepted |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 20 | Sink register address |
| bus_wdata | output | 8 | Write byte |
| bus_done | input | 1 | Accepted request finished |
| bus_rdata | input | 8 | Read byte, valid with `bus_done` |
| drive_set | output | 32 | Drive byte per lane, lane 0 in bits 7:0 |
| rate_code | output | 8 | Current link rate code |
| busy | output | 1 | Training in progress |
| train_done | output | 1 | One-cycle completion pulse |
| train_pass | output | 1 | Outcome, valid with `train_done` |

## Verification
A reactive sink model answers from the drive bytes actually written. It runs in one of three request patterns. The first raises swing by one step each attempt, up to a raw 3, and separates clamping and the level-2 path from early success. The second repeats the applied settings, and separates five tolerated identical requests from the sixth, which aborts. The third alternates pre-emphasis so that no two requests match, which isolates the ten-attempt limit from the repeat limit. Per-rate success masks force fallback to one or both lower rates. Lane counts of 1, 2 and 4 and several settle values, including zero and below-minimum, exercise lane masking and the settle clamp.

// File: rtl/dpcr_pkg.sv
package dpcr_pkg;

    localparam int NUM_RATES = 3;

    typedef struct packed {
        logic [1:0] pre;
        logic [1:0] swing;
    } drive_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_RATE,
        ST_W_LCNT,
        ST_W_PAT,
        ST_W_LSET,
        ST_SETTLE,
        ST_R_ST0,
        ST_R_ST1,
        ST_R_ADJ0,
        ST_R_ADJ1,
        ST_EVAL,
        ST_W_OFF,
        ST_FIN
    } tstate_e;

    localparam logic [19:0] REG_RATE  = 20'h00100;
    localparam logic [19:0] REG_LCNT  = 20'h00101;
    localparam logic [19:0] REG_PAT   = 20'h00102;
    localparam logic [19:0] REG_LSET  = 20'h00103;
    localparam logic [19:0] REG_STA0  = 20'h00202;
    localparam logic [19:0] REG_STA1  = 20'h00203;
    localparam logic [19:0] REG_ADJ0  = 20'h00206;
    localparam logic [19:0] REG_ADJ1  = 20'h00207;

    localparam logic [7:0] PAT_CR  = 8'h01;
    localparam logic [7:0] PAT_OFF = 8'h00;

    // rate index 0 is the fastest
    function automatic logic [7:0] rate_of(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h14;
            2'd1:    return 8'h0A;
            default: return 8'h06;
        endcase
    endfunction

    function automatic logic [7:0] lane_byte(input drive_t d);
        return {2'b00, (d.pre == 2'd2), d.pre, (d.swing == 2'd2), d.swing};
    endfunction

    function automatic logic [1:0] clamp_lvl(input logic [1:0] v);
        return (v == 2'd3) ? 2'd2 : v;
    endfunction

endpackage

// File: rtl/dpcr_settle_timer.sv
module dpcr_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    assign expired = (cnt >= target);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4
    settle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && !expired) |=> (cnt == $past(cnt) + 1'b1));

    // R4
    settle_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == '0));

endmodule

// File: rtl/dpcr_adjust_eval.sv
module dpcr_adjust_eval
    import dpcr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [7:0]             st_lo,
    input  logic [7:0]             st_hi,
    input  logic [7:0]             adj_lo,
    input  logic [7:0]             adj_hi,
    input  logic [2:0]             lane_count,
    input  drive_t [LANES-1:0]     cur,
    output drive_t [LANES-1:0]     nxt,
    output logic                   cr_ok,
    output logic                   same_req
);

    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_same;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SH = (i % 2) * 4;
        logic [7:0] st_b;
        logic [7:0] adj_b;
        logic       active;

        if (i < 2) begin : g_lo
            assign st_b  = st_lo;
            assign adj_b = adj_lo;
        end else begin : g_hi
            assign st_b  = st_hi;
            assign adj_b = adj_hi;
        end

        assign active       = (3'(i) < lane_count);
        assign lane_ok[i]   = !active || st_b[SH];
        assign nxt[i].swing = active ? clamp_lvl(adj_b[SH+1 -: 2]) : 2'd0;
        assign nxt[i].pre   = active ? clamp_lvl(adj_b[SH+3 -: 2]) : 2'd0;
        assign lane_same[i] = !active || (nxt[i] == cur[i]);
    end

    assign cr_ok    = &lane_ok;
    assign same_req = &lane_same;

endmodule

// File: rtl/dp_cr_trainer.sv
module dp_cr_trainer
    import dpcr_pkg::*;
#(
    parameter int LANES         = 4,
    parameter int ADDR_W        = 20,
    parameter int ATTEMPT_MAX   = 10,
    parameter int REPEAT_OK     = 5,
    parameter int SETTLE_MIN_US = 100,
    parameter int SETTLE_DEF_US = 200,
    parameter int TICK_W        = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2:0]           lane_count,
    input  logic [TICK_W-1:0]    settle_us,
    input  logic                 us_tick,
    output logic                 bus_valid,
    input  logic                 bus_ready,
    output logic                 bus_write,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [7:0]           bus_wdata,
    input  logic                 bus_done,
    input  logic [7:0]           bus_rdata,
    output logic [8*LANES-1:0]   drive_set,
    output logic [7:0]           rate_code,
    output logic                 busy,
    output logic                 train_done,
    output logic                 train_pass
);

    localparam int ATT_W     = $clog2(ATTEMPT_MAX + 1);
    localparam int REP_W     = $clog2(REPEAT_OK + 2);
    localparam int LIDX_W    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int RATE_LAST = NUM_RATES - 1;

    tstate_e               st;
    logic                  waiting;
    logic [1:0]            rate_idx;
    logic [LIDX_W-1:0]     lidx;
    drive_t [LANES-1:0]    drv;
    drive_t [LANES-1:0]    drv_nxt;
    logic [7:0]            st_lo, st_hi, adj_lo, adj_hi;
    logic [ATT_W-1:0]      att_cnt;
    logic [REP_W-1:0]      rep_cnt;
    logic [2:0]            lanes_r;
    logic [TICK_W-1:0]     settle_tgt;
    logic [TICK_W-1:0]     tmr_cnt;
    logic                  tmr_exp;
    logic                  tmr_load;
    logic                  pass_r;
    logic                  is_op;
    logic                  xfer_end;
    logic                  last_lane;
    logic                  cr_ok;
    logic                  same_req;
    logic                  rate_over;

    // ---------------- request decode ----------------
    always_comb begin
        is_op     = 1'b1;
        bus_write = 1'b1;
        bus_addr  = '0;
        bus_wdata = '0;
        case (st)
            ST_W_RATE: begin bus_addr = ADDR_W'(REG_RATE); bus_wdata = rate_of(rate_idx); end
            ST_W_LCNT: begin bus_addr = ADDR_W'(REG_LCNT); bus_wdata = {5'd0, lanes_r}; end
            ST_W_PAT:  begin bus_addr = ADDR_W'(REG_PAT);  bus_wdata = PAT_CR; end
            ST_W_LSET: begin
                bus_addr  = ADDR_W'(REG_LSET) + ADDR_W'(lidx);
                bus_wdata = lane_byte(drv[lidx]);
            end
            ST_R_ST0:  begin bus_write = 1'b0; bus_addr = ADDR_W'(REG_STA0); end
            ST_R_ST1:  begin bus_write = 1'b0; bus_addr = ADDR_W'(REG_STA1); end
            ST_R_ADJ0: begin bus_write = 1'b0; bus_addr = ADDR_W'(REG_ADJ0); end
            ST_R_ADJ1: begin bus_write = 1'b0; bus_addr = ADDR_W'(REG_ADJ1); end
            ST_W_OFF:  begin bus_addr = ADDR_W'(REG_PAT);  bus_wdata = PAT_OFF; end
            default:   is_op = 1'b0;
        endcase
    end

    assign bus_valid = is_op && !waiting;
    assign xfer_end  = is_op && waiting && bus_done;
    assign last_lane = ({1'b0, lidx} == 3'(lanes_r - 3'd1));
    assign tmr_load  = (st == ST_W_LSET) && xfer_end && last_lane;
    assign rate_over = (att_cnt == ATT_W'(ATTEMPT_MAX - 1)) ||
                       (same_req && (rep_cnt == REP_W'(REPEAT_OK)));

    // ---------------- sub-blocks ----------------
    dpcr_settle_timer #(.CNT_W(TICK_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .tick    (us_tick),
        .target  (settle_tgt),
        .cnt     (tmr_cnt),
        .expired (tmr_exp)
    );

    dpcr_adjust_eval #(.LANES(LANES)) u_eval (
        .st_lo      (st_lo),
        .st_hi      (st_hi),
        .adj_lo     (adj_lo),
        .adj_hi     (adj_hi),
        .lane_count (lanes_r),
        .cur        (drv),
        .nxt        (drv_nxt),
        .cr_ok      (cr_ok),
        .same_req   (same_req)
    );

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            waiting    <= 1'b0;
            rate_idx   <= '0;
            lidx       <= '0;
            drv        <= '0;
            st_lo      <= '0;
            st_hi      <= '0;
            adj_lo     <= '0;
            adj_hi     <= '0;
            att_cnt    <= '0;
            rep_cnt    <= '0;
            lanes_r    <= 3'd1;
            settle_tgt <= TICK_W'(SETTLE_DEF_US);
            pass_r     <= 1'b0;
        end else begin
            if (bus_valid && bus_ready) waiting <= 1'b1;
            if (xfer_end)               waiting <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    rate_idx <= '0;
                    lanes_r  <= lane_count;
                    drv      <= '0;
                    att_cnt  <= '0;
                    rep_cnt  <= '0;
                    pass_r   <= 1'b0;
                    if (settle_us == '0)
                        settle_tgt <= TICK_W'(SETTLE_DEF_US);
                    else if (settle_us < TICK_W'(SETTLE_MIN_US))
                        settle_tgt <= TICK_W'(SETTLE_MIN_US);
                    else
                        settle_tgt <= settle_us;
                    st <= ST_W_RATE;
                end
                ST_W_RATE: if (xfer_end) st <= ST_W_LCNT;
                ST_W_LCNT: if (xfer_end) st <= ST_W_PAT;
                ST_W_PAT: if (xfer_end) begin
                    lidx <= '0;
                    st   <= ST_W_LSET;
                end
                ST_W_LSET: if (xfer_end) begin
                    if (last_lane) st <= ST_SETTLE;
                    else           lidx <= lidx + 1'b1;
                end
                ST_SETTLE: if (tmr_exp) st <= ST_R_ST0;
                ST_R_ST0: if (xfer_end) begin st_lo  <= bus_rdata; st <= ST_R_ST1;  end
                ST_R_ST1: if (xfer_end) begin st_hi  <= bus_rdata; st <= ST_R_ADJ0; end
                ST_R_ADJ0: if (xfer_end) begin adj_lo <= bus_rdata; st <= ST_R_ADJ1; end
                ST_R_ADJ1: if (xfer_end) begin adj_hi <= bus_rdata; st <= ST_EVAL;   end
                ST_EVAL: begin
                    if (cr_ok) begin
                        pass_r <= 1'b1;
                        st     <= ST_W_OFF;
                    end else if (rate_over) begin
                        if (rate_idx == 2'(RATE_LAST)) begin
                            pass_r <= 1'b0;
                            st     <= ST_W_OFF;
                        end else begin
                            rate_idx <= rate_idx + 1'b1;
                            drv      <= '0;
                            att_cnt  <= '0;
                            rep_cnt  <= '0;
                            st       <= ST_W_RATE;
                        end
                    end else begin
                        drv     <= drv_nxt;
                        att_cnt <= att_cnt + 1'b1;
                        rep_cnt <= same_req ? rep_cnt + 1'b1 : '0;
                        lidx    <= '0;
                        st      <= ST_W_LSET;
                    end
                end
                ST_W_OFF: if (xfer_end) st <= ST_FIN;
                ST_FIN:   st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign drive_set[8*i +: 8] = lane_byte(drv[i]);
    end

    assign rate_code  = rate_of(rate_idx);
    assign busy       = (st != ST_IDLE);
    assign train_done = (st == ST_FIN);
    assign train_pass = pass_r;

    // ---------------- checks ----------------
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                       $stable(bus_wdata) && $stable(bus_write)));

    // R11
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> !bus_valid);

    // R3
    lane_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && (bus_addr >= ADDR_W'(REG_LSET)) &&
         (bus_addr < ADDR_W'(REG_LSET) + ADDR_W'(LANES)))
        |-> ((bus_wdata[2] == (bus_wdata[1:0] == 2'd2)) &&
             (bus_wdata[5] == (bus_wdata[4:3] == 2'd2)) &&
             (bus_wdata[1:0] != 2'd3) && (bus_wdata[7:6] == 2'b00)));

    // R4
    settle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_SETTLE) && tmr_exp) |-> (tmr_cnt >= TICK_W'(SETTLE_MIN_US)));

    // R8
    attempt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        att_cnt < ATT_W'(ATTEMPT_MAX));

    // R7
    repeat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rep_cnt <= REP_W'(REPEAT_OK));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        train_done |=> (!train_done && !busy));

endmodule

// File: tb/test_dp_cr_trainer.sv
module test_dp_cr_trainer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  lane_count = 3'd4;
    logic [15:0] settle_us = 16'd0;
    logic        us_tick = 1'b0;
    logic        bus_ready = 1'b0;
    logic        bus_done = 1'b0;
    logic [7:0]  bus_rdata = 8'd0;
    wire         bus_valid, bus_write;
    wire [19:0]  bus_addr;
    wire [7:0]   bus_wdata;
    wire [31:0]  drive_set;
    wire [7:0]   rate_code;
    wire         busy, train_done, train_pass;

    dp_cr_trainer i_dp_cr_trainer (
        .clk(clk), .rst(rst), .start(start), .lane_count(lane_count),
        .settle_us(settle_us), .us_tick(us_tick),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .drive_set(drive_set), .rate_code(rate_code),
        .busy(busy), .train_done(train_done), .train_pass(train_pass)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit tmo = 1'b0;

    // scenario of the sink model
    int     sc_lanes, sc_mode, sc_target, sc_okafter, sc_settle;
    bit [2:0] sc_mask;

    // expected results
    bit          exp_pass;
    logic [7:0]  exp_rate;
    logic [31:0] exp_drive;

    // scoreboard queues
    bit          q_wr[$];
    logic [19:0] q_addr[$];
    logic [7:0]  q_data[$];
    string       q_tag[$];

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rcode(int r);
        case (r)
            0:       return 8'h14;
            1:       return 8'h0A;
            default: return 8'h06;
        endcase
    endfunction

    function automatic logic [7:0] lbyte(int s, int p);
        logic [7:0] b;
        b = 8'(s) | (8'(p) << 3);
        if (s == 2) b = b | 8'h04;
        if (p == 2) b = b | 8'h20;
        return b;
    endfunction

    // raw request of the sink model for one lane
    function automatic int req_sw(int s);
        if (sc_mode == 0) return (s >= 3) ? 3 : s + 1;
        if (sc_mode == 1) return s;
        return 0;
    endfunction

    function automatic int req_pr(int p);
        if (sc_mode == 0) return 1;
        if (sc_mode == 1) return p;
        return (p == 0) ? 1 : 0;
    endfunction

    function automatic bit sink_ok(int r, int sw[4], int n);
        bit ok;
        ok = sc_mask[r] && (n >= sc_okafter);
        for (int i = 0; i < sc_lanes; i++)
            if (sw[i] < sc_target) ok = 1'b0;
        return ok;
    endfunction

    task automatic push(bit wr, logic [19:0] a, logic [7:0] d, string tag);
        q_wr.push_back(wr);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // driver: expected transaction stream from the requirements
    task automatic plan_run();
        int ds[4];
        int dp[4];
        int att, rep, rs, rp;
        bit ok, same;
        exp_pass = 1'b0;
        for (int r = 0; r < 3; r++) begin
            push(1'b1, 20'h100, rcode(r), "R9");
            push(1'b1, 20'h101, 8'(sc_lanes), "R2");
            push(1'b1, 20'h102, 8'h01, "R2");
            for (int i = 0; i < 4; i++) begin ds[i] = 0; dp[i] = 0; end
            att = 0;
            rep = 0;
            forever begin
                for (int i = 0; i < sc_lanes; i++)
                    push(1'b1, 20'h103 + 20'(i), lbyte(ds[i], dp[i]), "R3");
                push(1'b0, 20'h202, 8'h00, "R5");
                push(1'b0, 20'h203, 8'h00, "R5");
                push(1'b0, 20'h206, 8'h00, "R5");
                push(1'b0, 20'h207, 8'h00, "R5");
                ok = sink_ok(r, ds, att + 1);
                if (ok) begin exp_pass = 1'b1; break; end
                same = 1'b1;
                for (int i = 0; i < sc_lanes; i++) begin
                    rs = req_sw(ds[i]); if (rs > 2) rs = 2;
                    rp = req_pr(dp[i]); if (rp > 2) rp = 2;
                    if (rs != ds[i] || rp != dp[i]) same = 1'b0;
                end
                att++;
                rep = same ? rep + 1 : 0;
                if (att == 10 || rep == 6) break;
                for (int i = 0; i < sc_lanes; i++) begin
                    rs = req_sw(ds[i]); if (rs > 2) rs = 2;
                    rp = req_pr(dp[i]); if (rp > 2) rp = 2;
                    ds[i] = rs;
                    dp[i] = rp;
                end
            end
            exp_rate  = rcode(r);
            exp_drive = '0;
            for (int i = 0; i < sc_lanes; i++)
                exp_drive[8*i +: 8] = lbyte(ds[i], dp[i]);
            if (exp_pass) break;
        end
        push(1'b1, 20'h102, 8'h00, "R10");
    endtask

    // monitor and reactive sink: one process at the falling edge
    int  ph = 0;
    int  s_rate = 0;
    int  s_cnt = 0;
    bit  s_ok = 1'b0;
    logic [7:0] lset[4];
    logic [7:0] rd_next;
    bit  meas = 1'b0;
    bit  lset_pending = 1'b0;
    int  tcnt = 0;

    initial begin
        for (int i = 0; i < 4; i++) lset[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (meas && us_tick) tcnt++;
            us_tick = ~us_tick;
            bus_ready = 1'b0;
            if (!rst) begin
                if (ph == 0) begin
                    bus_done = 1'b0;
                    if (bus_valid) begin
                        if (q_wr.size() == 0) begin
                            chk(1'b0, "R2", "unexpected request", {12'h0, bus_addr}, 32'h0);
                        end else begin
                            bit  ew;
                            logic [19:0] ea;
                            logic [7:0]  ed;
                            string et;
                            ew = q_wr.pop_front();
                            ea = q_addr.pop_front();
                            ed = q_data.pop_front();
                            et = q_tag.pop_front();
                            chk(bus_write == ew && bus_addr == ea && (!ew || bus_wdata == ed), et,
                                "request wr/addr/data", {3'b0, bus_write, bus_addr, bus_wdata},
                                {3'b0, ew, ea, ed});
                        end
                        if (!bus_write && bus_addr == 20'h202 && meas) begin
                            chk(tcnt >= sc_settle - 1 && tcnt <= sc_settle + 1, "R4",
                                "settle ticks", 32'(tcnt), 32'(sc_settle));
                            meas = 1'b0;
                        end
                        rd_next = 8'h00;
                        lset_pending = 1'b0;
                        if (bus_write) begin
                            if (bus_addr == 20'h100) begin
                                s_rate = (bus_wdata == 8'h14) ? 0 : (bus_wdata == 8'h0A) ? 1 : 2;
                                s_cnt = 0;
                            end
                            if (bus_addr >= 20'h103 && bus_addr <= 20'h106) begin
                                lset[bus_addr - 20'h103] = bus_wdata;
                                lset_pending = 1'b1;
                            end
                        end else begin
                            int sw[4];
                            for (int i = 0; i < 4; i++) sw[i] = int'(lset[i][1:0]);
                            if (bus_addr == 20'h202) begin
                                s_cnt++;
                                s_ok = sink_ok(s_rate, sw, s_cnt);
                            end
                            if (bus_addr == 20'h202 || bus_addr == 20'h203)
                                rd_next = s_ok ? 8'h11 : 8'h00;
                            if (bus_addr == 20'h206 || bus_addr == 20'h207) begin
                                int b;
                                b = (bus_addr == 20'h206) ? 0 : 2;
                                for (int k = 0; k < 2; k++) begin
                                    int rsw, rpr;
                                    rsw = req_sw(int'(lset[b+k][1:0]));
                                    rpr = req_pr(int'(lset[b+k][4:3]));
                                    rd_next = rd_next | ((8'(rsw) | (8'(rpr) << 2)) << (4 * k));
                                end
                            end
                        end
                        bus_ready = 1'b1;
                        ph = 2;
                    end
                end else if (ph == 2) begin
                    chk(!bus_valid, "R11", "no request while awaiting done", 32'(bus_valid), 32'h0);
                    ph = 1;
                end else begin
                    bus_done = 1'b1;
                    bus_rdata = rd_next;
                    if (lset_pending) begin meas = 1'b1; tcnt = 0; end
                    ph = 0;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        tmo = 1'b1;
    end

    task automatic run_case(int lanes, int mode, int tgt, int okafter, bit [2:0] mask,
                            int settle_in, int settle_exp, string rq);
        sc_lanes = lanes; sc_mode = mode; sc_target = tgt; sc_okafter = okafter;
        sc_mask = mask; sc_settle = settle_exp;
        lane_count = 3'(lanes);
        settle_us = 16'(settle_in);
        plan_run();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!train_done && !tmo) @(negedge clk);
        if (tmo) return;
        chk(train_pass == exp_pass, rq, "pass flag", 32'(train_pass), 32'(exp_pass));
        chk(rate_code == exp_rate, rq, "final rate", 32'(rate_code), 32'(exp_rate));
        chk(drive_set == exp_drive, "R6", "final drive", drive_set, exp_drive);
        chk(q_wr.size() == 0, "R10", "pending expected requests", 32'(q_wr.size()), 32'h0);
        @(negedge clk);
        chk(!train_done && !busy, "R10", "done lasts one cycle", {30'h0, train_done, busy}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !bus_valid && !train_done, "R1", "idle outputs",
            {29'h0, busy, bus_valid, train_done}, 32'h0);
        chk(drive_set == 32'h0, "R1", "drive after reset", drive_set, 32'h0);
        chk(rate_code == 8'h14, "R1", "rate after reset", 32'(rate_code), 32'h14);

        // R6 raise to swing 2 with clamp, success on first rate, default settle (R4)
        if (!tmo) run_case(4, 0, 2, 0, 3'b111, 0, 200, "R6");
        // R9 first rate never succeeds, clamped repeats end it, pass at 0x0A; settle raised to 100
        if (!tmo) run_case(2, 0, 2, 0, 3'b110, 50, 100, "R9");
        // R7 five identical requests tolerated, success on the sixth attempt
        if (!tmo) run_case(4, 1, 0, 6, 3'b001, 100, 100, "R7");
        // R7 sixth identical request aborts every rate, final failure
        if (!tmo) run_case(1, 1, 0, 7, 3'b001, 120, 120, "R7");
        // R8 alternating requests, ten attempts per rate, final failure
        if (!tmo) run_case(4, 2, 0, 0, 3'b000, 150, 150, "R8");
        // R5 immediate success with two lanes
        if (!tmo) run_case(2, 1, 0, 0, 3'b111, 101, 101, "R5");

        if (tmo) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog expired: actual running expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule